// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block drives the contact side of a smart card slot from a handful of host controls. A falling edge on the active-low power command starts a timed power-up. The block first enables the card supply and checks that the supply came up. It then releases the I/O line into reception mode and starts the card clock. It passes the host reset request to the card only once the card clock has run for a minimum number of cycles.

A rising power command, a card withdrawal or a supply collapse triggers a timed power-down. The card reset drops first, then the clock stops, then the I/O line is pulled low, and last the supply is switched off. A discharge interval follows before a new power-up is accepted. A supply failure is reported on the active-low `off_n` output and held there until the host withdraws its power command. All intervals are counted in cycles of the system clock.

A settling interval follows system reset and every exit from sleep. Power commands that arrive during it are discarded.

Top module: `card_seq`

## Requirements
- R1: After `rst_n` is released or `sleep` falls, `vcc_en`, `card_rst`, `card_clk` and `io_rx` are low, and falling edges of `cmd_vcc_n` during the following `SETTLE_CYC` cycles start nothing.
- R2: Power-up starts only on a falling edge of `cmd_vcc_n` seen while idle with `card_ok` high. A steady low level, or an edge while `card_ok` is low, does not start it.
- R3: `vcc_en` rises in the cycle after the falling edge. `T1_CYC` cycles later `vcc_good` is sampled. If it is low, `vcc_en` drops, `off_n` goes low and the clock and I/O are never enabled.
- R4: `io_rx` rises `T1_CYC+T2_CYC` cycles after `vcc_en` rises. The clock gate opens `T3_CYC` cycles after that, and `card_clk` equals `clk_strobe` while the gate is open.
- R5: `card_rst` follows `rst_req` only after `T4_CYC` more cycles, and only once `RST_HOLD` rising edges of `clk_strobe` have been counted with the gate open. Until then it stays low, even if `rst_req` is high.
- R6: Power-down starts when `cmd_vcc_n` is high, when `card_ok` is low, or when `vcc_good` is low after the T1 check, at any point between the supply turning on and the end of the active phase.
- R7: During power-down, `card_rst` falls `D_RST_CYC` cycles after the start. The clock stops at least `D_CLK_CYC` cycles after that. `io_rx` falls `D_IO_CYC` cycles after the clock stops, and `vcc_en` falls one cycle after `io_rx`.
- R8: A power-down started by the command closes the clock gate only while `clk_strobe` is low, so no card clock pulse is cut short. A power-down caused by the card or the supply closes it exactly `D_CLK_CYC` cycles after `card_rst` falls.
- R9: The block returns to idle `DISCH_CYC` cycles after power-down starts. Command edges before that are ignored.
- R10: `off_n` equals `card_ok` except after a supply fault. A supply fault holds `off_n` low, with the supply off, until `cmd_vcc_n` is seen high.
- R11: `sleep` high switches all card outputs off in the next cycle, from any state, and restarts the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down mode request, active high |
| cmd_vcc_n | input | 1 | Active-low card power command, edge triggered |
| rst_req | input | 1 | Host request for the card reset level |
| clk_strobe | input | 1 | Card clock source from the divider |
| card_ok | input | 1 | Card present and no external fault, high when good |
| vcc_good | input | 1 | Card supply within range |
| vcc_en | output | 1 | Card supply enable |
| card_rst | output | 1 | Card reset line |
| card_clk | output | 1 | Gated card clock |
| io_rx | output | 1 | I/O in reception mode when high, held low when low |
| off_n | output | 1 | Active-low card absent or fault report |

## Verification
The bench targets the reset hold. A design that starts the hold count when the supply turns on, or that passes `rst_req` straight through, raises `card_rst` after too few card clock edges. It checks a command-initiated power-down against one caused by card removal: a gate that closes without waiting for `clk_strobe` low leaves a single short clock pulse, and one that always waits adds cycles where the exact `D_CLK_CYC` spacing is expected. It fires command edges during settling, during discharge and with no card present; a design that takes levels instead of edges, or leaves idle too early, powers the card when it must not. The two fault paths (at the T1 check and in the active phase) show whether `off_n` is held until the command is withdrawn or released early.

// File: rtl/card_seq.sv
module card_seq #(
  parameter int SETTLE_CYC = 1250000,
  parameter int T1_CYC     = 16000,
  parameter int T2_CYC     = 1000,
  parameter int T3_CYC     = 1000,
  parameter int T4_CYC     = 1000,
  parameter int RST_HOLD   = 42000,
  parameter int D_RST_CYC  = 63,
  parameter int D_CLK_CYC  = 938,
  parameter int D_IO_CYC   = 250,
  parameter int DISCH_CYC  = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic cmd_vcc_n,
  input  logic rst_req,
  input  logic clk_strobe,
  input  logic card_ok,
  input  logic vcc_good,
  output logic vcc_en,
  output logic card_rst,
  output logic card_clk,
  output logic io_rx,
  output logic off_n
);

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = maxi(maxi(maxi(SETTLE_CYC, DISCH_CYC), maxi(T1_CYC, T2_CYC)),
                             maxi(maxi(T3_CYC, T4_CYC), maxi(maxi(D_RST_CYC, D_CLK_CYC), D_IO_CYC)));
  localparam int CW = $clog2(MAXC + 1);
  localparam int HW = $clog2(RST_HOLD + 1);

  typedef enum logic [3:0] {
    S_PUP, S_IDLE, S_T1, S_T2, S_T3, S_T4, S_ACT,
    S_DRST, S_DCLK, S_DIO, S_DVCC, S_DISCH, S_FAULT
  } state_t;

  state_t         st;
  logic [CW-1:0]  cnt, dcnt;
  logic [HW-1:0]  hcnt;
  logic           gate, flt, off_cause, cmd_q, stb_q;

  wire cmd_fall = cmd_q & ~cmd_vcc_n;
  wire stb_rise = clk_strobe & ~stb_q;
  wire hold_ok  = (hcnt == HW'(RST_HOLD));
  wire live     = (st == S_T1) | (st == S_T2) | (st == S_T3) | (st == S_T4) | (st == S_ACT);
  wire sup_bad  = (st != S_T1) & ~vcc_good;
  wire drop_req = cmd_vcc_n | ~card_ok | sup_bad;

  assign card_clk = clk_strobe & gate;
  assign off_n    = card_ok & ~flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PUP;
      cnt       <= '0;
      dcnt      <= '0;
      hcnt      <= '0;
      vcc_en    <= 1'b0;
      card_rst  <= 1'b0;
      gate      <= 1'b0;
      io_rx     <= 1'b0;
      flt       <= 1'b0;
      off_cause <= 1'b0;
      cmd_q     <= 1'b1;
      stb_q     <= 1'b0;
    end else begin
      cmd_q <= cmd_vcc_n;
      stb_q <= clk_strobe;
      cnt   <= cnt + 1'b1;
      dcnt  <= dcnt + 1'b1;

      if (!gate)                 hcnt <= '0;
      else if (stb_rise && !hold_ok) hcnt <= hcnt + 1'b1;

      if (sleep) begin
        st       <= S_PUP;
        cnt      <= '0;
        vcc_en   <= 1'b0;
        card_rst <= 1'b0;
        gate     <= 1'b0;
        io_rx    <= 1'b0;
        flt      <= 1'b0;
      end else if (live && drop_req) begin
        st        <= S_DRST;
        cnt       <= '0;
        dcnt      <= '0;
        off_cause <= ~card_ok | sup_bad;
        flt       <= sup_bad;
      end else begin
        case (st)
          S_PUP:
            if (cnt == CW'(SETTLE_CYC - 1)) st <= S_IDLE;
          S_IDLE:
            if (cmd_fall && card_ok) begin
              st     <= S_T1;
              cnt    <= '0;
              vcc_en <= 1'b1;
            end
          S_T1:
            if (cnt == CW'(T1_CYC - 1)) begin
              cnt <= '0;
              if (!vcc_good) begin
                st     <= S_FAULT;
                vcc_en <= 1'b0;
                flt    <= 1'b1;
              end else begin
                st <= S_T2;
              end
            end
          S_T2:
            if (cnt == CW'(T2_CYC - 1)) begin
              st    <= S_T3;
              cnt   <= '0;
              io_rx <= 1'b1;
            end
          S_T3:
            if (cnt == CW'(T3_CYC - 1)) begin
              st   <= S_T4;
              cnt  <= '0;
              gate <= 1'b1;
            end
          S_T4:
            if (cnt == CW'(T4_CYC - 1)) begin
              st  <= S_ACT;
              cnt <= '0;
            end
          S_ACT:
            card_rst <= rst_req & hold_ok;
          S_DRST:
            if (cnt == CW'(D_RST_CYC - 1)) begin
              st       <= S_DCLK;
              cnt      <= '0;
              card_rst <= 1'b0;
            end
          S_DCLK:
            if (cnt >= CW'(D_CLK_CYC - 1) && (off_cause || !clk_strobe)) begin
              st   <= S_DIO;
              cnt  <= '0;
              gate <= 1'b0;
            end
          S_DIO:
            if (cnt == CW'(D_IO_CYC - 1)) begin
              st    <= S_DVCC;
              io_rx <= 1'b0;
            end
          S_DVCC: begin
            st     <= S_DISCH;
            vcc_en <= 1'b0;
          end
          S_DISCH:
            if (dcnt >= CW'(DISCH_CYC - 1)) begin
              st        <= flt ? S_FAULT : S_IDLE;
              off_cause <= 1'b0;
            end
          S_FAULT:
            if (cmd_vcc_n) begin
              st  <= S_IDLE;
              flt <= 1'b0;
            end
          default: st <= S_PUP;
        endcase
      end
    end
  end

endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk #(
  parameter int RST_HOLD = 42000
) (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic vcc_en,
  input logic card_rst,
  input logic card_clk,
  input logic io_rx,
  input logic off_n,
  input logic in_fault,
  input logic in_pup
);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [HW-1:0] ecnt;
  logic          ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      ck_q <= 1'b0;
    end else begin
      ck_q <= card_clk;
      if (!vcc_en) ecnt <= '0;
      else if (card_clk && !ck_q && ecnt != HW'(RST_HOLD)) ecnt <= ecnt + 1'b1;
    end
  end

  assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_pup |-> !vcc_en);

  assert_clean_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> (off_n && !io_rx && !card_rst));

  assert_io_needs_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rx |-> vcc_en);

  assert_rst_needs_io_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (vcc_en && io_rx));

  assert_rst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> (ecnt == HW'(RST_HOLD)));

  assert_pwr_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!io_rx && !card_rst && !card_clk));

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_fault |-> (!off_n && !vcc_en));

  assert_sleep_cut_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !vcc_en);

endmodule

bind card_seq card_seq_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .vcc_en(vcc_en), .card_rst(card_rst),
  .card_clk(card_clk), .io_rx(io_rx), .off_n(off_n),
  .in_fault(st == S_FAULT), .in_pup(st == S_PUP)
);

// File: tb/test_card_seq.sv
`timescale 1ns/1ps
module test_card_seq;
  localparam int SETTLE = 50, T1 = 20, T2 = 10, T3 = 10, T4 = 30, HOLD = 16;
  localparam int DR = 8, DC = 12, DIO = 6, DIS = 100;

  logic clk = 0, rst_n = 0, sleep = 0, cmd_vcc_n = 1, rst_req = 1;
  logic clk_strobe = 0, card_ok = 1, vcc_good = 1;
  logic vcc_en, card_rst, card_clk, io_rx, off_n;
  int checks = 0, errors = 0;
  int clk_rises = 0, run = 0;
  bit short_pulse = 0, ck_prev = 0;
  logic [1:0] sc = 0;

  always #4 clk = ~clk;

  card_seq #(.SETTLE_CYC(SETTLE), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3), .T4_CYC(T4),
             .RST_HOLD(HOLD), .D_RST_CYC(DR), .D_CLK_CYC(DC), .D_IO_CYC(DIO),
             .DISCH_CYC(DIS)) i_card_seq (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cmd_vcc_n(cmd_vcc_n), .rst_req(rst_req),
    .clk_strobe(clk_strobe), .card_ok(card_ok), .vcc_good(vcc_good), .vcc_en(vcc_en),
    .card_rst(card_rst), .card_clk(card_clk), .io_rx(io_rx), .off_n(off_n));

  always @(posedge clk) begin
    #1;
    sc = sc + 1'b1;
    clk_strobe = sc[1];
  end

  always @(negedge clk) begin
    if (card_clk && !ck_prev) clk_rises++;
    if (card_clk) run++;
    else begin
      if (ck_prev && run < 2) short_pulse = 1;
      run = 0;
    end
    ck_prev = card_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return vcc_en;
      1: return card_rst;
      2: return card_clk;
      3: return io_rx;
      default: return off_n;
    endcase
  endfunction

  task automatic wait_on(input int sel, input logic val, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) !== val && n < lim);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up;
    int n;
    @(negedge clk); cmd_vcc_n = 1; idle(2); cmd_vcc_n = 0;
    wait_on(1, 1'b1, 3000, n);
    check(card_rst === 1'b1, "R5 power_up reached reset release", card_rst, 1);
  endtask

  task automatic t_reset;
    int n;
    check({vcc_en, card_rst, card_clk, io_rx} === 4'b0, "R1 outputs after reset",
          {vcc_en, card_rst, card_clk, io_rx}, 0);
    idle(SETTLE / 2); cmd_vcc_n = 0; idle(SETTLE + 10);
    check(vcc_en === 1'b0, "R1 edge during settle ignored", vcc_en, 0);
    cmd_vcc_n = 1; idle(2); cmd_vcc_n = 0;
    wait_on(0, 1'b1, 5, n);
    check(n == 1, "R1 edge after settle accepted, cycles", n, 1);
    cmd_vcc_n = 1; idle(DIS + 10);
  endtask

  task automatic t_no_card;
    @(negedge clk); card_ok = 0; idle(2);
    check(off_n === 1'b0, "R10 off_n follows card_ok low", off_n, 0);
    cmd_vcc_n = 0; idle(10);
    check(vcc_en === 1'b0, "R2 edge without card ignored", vcc_en, 0);
    card_ok = 1; idle(10);
    check(vcc_en === 1'b0, "R2 steady low level ignored", vcc_en, 0);
    check(off_n === 1'b1, "R10 off_n follows card_ok high", off_n, 1);
    cmd_vcc_n = 1; idle(2);
  endtask

  task automatic t_activate;
    int n;
    @(negedge clk); rst_req = 1; cmd_vcc_n = 0;
    wait_on(0, 1'b1, 10, n);
    check(n == 1, "R3 vcc_en delay", n, 1);
    wait_on(3, 1'b1, 200, n);
    check(n == T1 + T2, "R4 io_rx delay from vcc_en", n, T1 + T2);
    check(card_clk === 1'b0 && card_rst === 1'b0, "R4 no clock before io_rx", card_clk, 0);
    clk_rises = 0;
    wait_on(2, 1'b1, 200, n);
    check(n >= T3 && n <= T3 + 3, "R4 clock start from io_rx", n, T3);
    wait_on(1, 1'b1, 2000, n);
    check(clk_rises >= HOLD && clk_rises <= HOLD + 1, "R5 clock edges before reset release",
          clk_rises, HOLD);
    rst_req = 0;
    wait_on(1, 1'b0, 10, n);
    check(n == 1, "R5 card_rst follows rst_req low", n, 1);
    rst_req = 1;
    wait_on(1, 1'b1, 10, n);
    check(n == 1, "R5 card_rst follows rst_req high", n, 1);
  endtask

  task automatic t_deact_cmd;
    int n, m;
    bit stayed = 1;
    @(negedge clk); short_pulse = 0; cmd_vcc_n = 1;
    wait_on(1, 1'b0, 100, n);
    check(n == DR + 1, "R7 card_rst fall after command", n, DR + 1);
    check(io_rx === 1'b1 && vcc_en === 1'b1, "R7 io and supply still on", io_rx, 1);
    wait_on(3, 1'b0, 100, m);
    check(m >= DC + DIO && m <= DC + DIO + 3, "R7 io_rx fall after reset (command)", m, DC + DIO);
    check(short_pulse == 0, "R8 no short clock pulse on command stop", short_pulse, 0);
    wait_on(0, 1'b0, 10, n);
    check(n == 1, "R7 vcc_en falls after io_rx", n, 1);
    cmd_vcc_n = 0;
    repeat (DIS) begin
      @(negedge clk);
      if (vcc_en !== 1'b0) stayed = 0;
    end
    check(stayed, "R9 edge during discharge ignored", vcc_en, 0);
    cmd_vcc_n = 1; idle(2); cmd_vcc_n = 0;
    wait_on(0, 1'b1, 5, n);
    check(n == 1, "R9 power-up accepted after discharge", n, 1);
    wait_on(1, 1'b1, 3000, n);
  endtask

  task automatic t_remove;
    int n, m;
    @(negedge clk); card_ok = 0;
    @(negedge clk);
    check(off_n === 1'b0, "R6 off_n low on card removal", off_n, 0);
    wait_on(1, 1'b0, 100, n);
    check(n == DR, "R6 card_rst fall after removal", n, DR);
    wait_on(3, 1'b0, 100, m);
    check(m == DC + DIO, "R8 exact clock stop on removal", m, DC + DIO);
    wait_on(0, 1'b0, 10, n);
    check(n == 1, "R7 vcc_en after io_rx on removal", n, 1);
    idle(DIS); card_ok = 1; @(negedge clk);
    check(off_n === 1'b1, "R10 no fault latched by removal", off_n, 1);
    cmd_vcc_n = 1; idle(2);
  endtask

  task automatic t_fault_t1;
    int n;
    bit io_seen = 0;
    @(negedge clk); vcc_good = 0; cmd_vcc_n = 0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (io_rx) io_seen = 1;
    end while (vcc_en !== 1'b0 || n < 2);
    check(n == T1 + 1, "R3 supply removed at T1 check", n, T1 + 1);
    check(off_n === 1'b0, "R3 off_n low at T1 fault", off_n, 0);
    check(!io_seen && card_clk === 1'b0, "R3 io and clock never enabled", io_seen, 0);
    vcc_good = 1; idle(20);
    check(off_n === 1'b0 && vcc_en === 1'b0, "R10 fault held while command low", off_n, 0);
    cmd_vcc_n = 1;
    wait_on(4, 1'b1, 10, n);
    check(n == 1, "R10 fault cleared by command high", n, 1);
  endtask

  task automatic t_fault_active;
    int n;
    power_up();
    @(negedge clk); vcc_good = 0;
    wait_on(4, 1'b0, 10, n);
    check(n == 1, "R6 off_n low on supply loss", n, 1);
    wait_on(0, 1'b0, 200, n);
    check(card_rst === 1'b0 && io_rx === 1'b0, "R7 order on supply loss", io_rx, 0);
    vcc_good = 1; idle(DIS + 10);
    check(off_n === 1'b0 && vcc_en === 1'b0, "R10 fault held after discharge", off_n, 0);
    cmd_vcc_n = 1;
    wait_on(4, 1'b1, 10, n);
    check(n == 1, "R10 fault released by command", n, 1);
  endtask

  task automatic t_sleep;
    int n;
    power_up();
    @(negedge clk); sleep = 1; cmd_vcc_n = 1;
    @(negedge clk);
    check({vcc_en, card_rst, io_rx} === 3'b0, "R11 sleep drops outputs",
          {vcc_en, card_rst, io_rx}, 0);
    idle(3); sleep = 0; @(negedge clk); cmd_vcc_n = 0; idle(SETTLE + 10);
    check(vcc_en === 1'b0, "R11 settle restarted after sleep", vcc_en, 0);
    cmd_vcc_n = 1; idle(2); cmd_vcc_n = 0;
    wait_on(0, 1'b1, 5, n);
    check(n == 1, "R11 power-up after sleep settle", n, 1);
    cmd_vcc_n = 1; idle(DIS + 10);
  endtask

  initial begin
    idle(3); rst_n = 1;
    t_reset();
    t_no_card();
    t_activate();
    t_deact_cmd();
    t_remove();
    t_fault_t1();
    t_fault_active();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule